// File: doc/BRIEF.md
# Pipeline Throughput, Utilization and Efficiency Monitor

This block watches a multi-stage instruction pipeline without influencing it. A start pulse opens an observation window of a programmable number of cycles. While the window runs, the monitor counts retired instructions (throughput X) and, for every stage, the cycles in which that stage reports itself busy (a raw utilization count U). It also holds a configured peak rate P, which is the most instructions the pipeline can retire in one busy cycle.

When the window closes, X, the window length, P and every busy count are copied into snapshot registers. The live counters clear, and unless stop is high in the final window cycle, a new window of the same length begins with no gap. A shared sequential divider then computes, stage by stage, the efficiency E = X / (U·P) as an unsigned Q1.15 fraction, where 0x8000 means 1.0. An ideal pipeline with no stalls or bubbles gives E = 1.0. Lost cycles push E below one. A done flag reports when all stages have been computed. Software reads everything through a registered read port with one cycle of latency.

Top module: `pipe_eff_mon`

## Requirements
- R1: A start pulse, while no window is active and win_len is nonzero, opens a window of exactly win_len cycles that begins in the cycle after the pulse. A start while a window is active is ignored, and so is a start with win_len of zero. The length is latched at start and read back at address 2.
- R2: The X snapshot (address 1) equals the number of cycles inside the window in which retire was high. Retire outside a window is not counted.
- R3: The busy snapshot of stage i (address 8+i) equals the number of window cycles in which busy bit i was high.
- R4: If stop is low in the last cycle of a window, the next window starts in the following cycle with cleared counters. If stop is high, counting halts until the next start.
- R5: The efficiency of stage i (address 16+i) equals floor(X·2^15 / (busy_i·P)) when X < busy_i·P, and 0x8000 otherwise. The peak P is sampled at window end and read back at address 3.
- R6: If busy_i is zero or P is zero, the efficiency of stage i is 0.
- R7: Status bit 0 (done) clears when a window ends and sets once every stage's efficiency is final.
- R8: Counters saturate at all ones instead of wrapping. A sticky flag is set for a counter that saturates: status bit 8 for X and bit 16+i for stage i.
- R9: rd_data shows the word selected by rd_addr one cycle later. Unmapped addresses read as zero.
- R10: A synchronous active-high reset clears the counters, snapshots, efficiencies and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a window when idle |
| stop | input | 1 | Suppresses the automatic restart at window end |
| win_len | input | WIN_W | Window length in cycles |
| peak | input | PEAK_W | Peak instructions per busy cycle |
| retire | input | 1 | One instruction retired this cycle |
| busy | input | NSTAGE | Per-stage busy flags, bit i for stage i |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |

## Verification
The hardest state to reach is the seamless restart: a second window has to follow the first with no lost cycle, while a stray start pulse lands in its middle and must leave its length untouched. The bench reaches this by holding stop low through the first window and raising it only during the second. It drives a distinct retire pattern in each window, so any leakage across the boundary, and any honoured restart, changes X. Saturation is reached with narrowed counters and a window longer than the counter range.

// File: rtl/pem_pkg.sv
package pem_pkg;
   localparam int unsigned FRAC_W  = 15;
   localparam int unsigned EFF_W   = FRAC_W + 1;
   localparam logic [EFF_W-1:0] EFF_ONE = EFF_W'(1) << FRAC_W;

   localparam int unsigned A_STATUS    = 0;
   localparam int unsigned A_XCNT      = 1;
   localparam int unsigned A_WIN       = 2;
   localparam int unsigned A_PEAK      = 3;
   localparam int unsigned A_BUSY_BASE = 8;
   localparam int unsigned A_EFF_BASE  = 16;
   localparam int unsigned ST_XOVF_BIT = 8;
   localparam int unsigned ST_SOVF_BIT = 16;

   typedef enum logic [1:0] {
      CS_IDLE,
      CS_PICK,
      CS_WAIT
   } calc_st_e;
endpackage

// File: rtl/pem_sat_cnt.sv
module pem_sat_cnt #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt,
   output logic [W-1:0] nxt,
   output logic         sat_hit
);
   always_comb begin
      sat_hit = inc && (cnt == {W{1'b1}});
      nxt     = (inc && !sat_hit) ? cnt + W'(1) : cnt;
   end

   always_ff @(posedge clk) begin
      if (rst || clr) cnt <= '0;
      else            cnt <= nxt;
   end
endmodule

// File: rtl/pem_frac_div.sv
module pem_frac_div #(
   parameter int unsigned DW = 20,
   parameter int unsigned QW = 15
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          go,
   input  logic [DW-1:0] num,
   input  logic [DW-1:0] den,
   output logic [QW-1:0] quo,
   output logic          fin
);
   localparam int unsigned CW = $clog2(QW + 1);

   logic [DW-1:0] rem;
   logic [CW-1:0] left;
   logic          run;
   logic [DW:0]   trial;
   logic          ge;

   always_comb begin
      trial = {rem, 1'b0};
      ge    = trial >= {1'b0, den};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rem  <= '0;
         quo  <= '0;
         left <= '0;
         run  <= 1'b0;
         fin  <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            rem  <= num;
            quo  <= '0;
            left <= CW'(QW);
            run  <= 1'b1;
         end else if (run) begin
            rem  <= ge ? DW'(trial - {1'b0, den}) : DW'(trial);
            quo  <= {quo[QW-2:0], ge};
            left <= left - CW'(1);
            if (left == CW'(1)) begin
               run <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pipe_eff_mon.sv
module pipe_eff_mon
   import pem_pkg::*;
#(
   parameter int unsigned NSTAGE = 4,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned WIN_W  = 16,
   parameter int unsigned PEAK_W = 4,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              stop,
   input  logic [WIN_W-1:0]  win_len,
   input  logic [PEAK_W-1:0] peak,
   input  logic              retire,
   input  logic [NSTAGE-1:0] busy,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned DEN_W = CNT_W + PEAK_W;
   localparam int unsigned IDX_W = (NSTAGE > 1) ? $clog2(NSTAGE) : 1;

   if (NSTAGE < 1 || NSTAGE > 8) begin : g_bad_nstage
      $error("pipe_eff_mon: NSTAGE must be 1..8");
   end
   if (CNT_W > DATA_W || WIN_W > DATA_W || PEAK_W > DATA_W || EFF_W > DATA_W) begin : g_bad_width
      $error("pipe_eff_mon: a field is wider than DATA_W");
   end
   if (DATA_W < ST_SOVF_BIT + NSTAGE) begin : g_bad_status
      $error("pipe_eff_mon: DATA_W too narrow for the status word");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("pipe_eff_mon: ADDR_W must be at least 5");
   end
   if (DEN_W <= FRAC_W / 2) begin : g_bad_den
      $error("pipe_eff_mon: divider datapath too narrow");
   end

   // ---------------- window control ----------------
   logic             active;
   logic [WIN_W-1:0] cyc;
   logic [WIN_W-1:0] t_reg;
   logic             snap_take;

   assign snap_take = active && (cyc == t_reg - WIN_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         cyc    <= '0;
         t_reg  <= '0;
      end else if (!active) begin
         if (start && (win_len != '0)) begin
            active <= 1'b1;
            cyc    <= '0;
            t_reg  <= win_len;
         end
      end else if (snap_take) begin
         cyc    <= '0;
         active <= !stop;
      end else begin
         cyc <= cyc + WIN_W'(1);
      end
   end

   // ---------------- live counters ----------------
   logic [CNT_W-1:0]              x_live, x_nxt;
   logic                          x_hit;
   logic [NSTAGE-1:0][CNT_W-1:0]  b_live, b_nxt;
   logic [NSTAGE-1:0]             b_hit;

   pem_sat_cnt #(.W(CNT_W)) u_xcnt (
      .clk(clk), .rst(rst), .clr(snap_take), .inc(active && retire),
      .cnt(x_live), .nxt(x_nxt), .sat_hit(x_hit)
   );

   for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
      pem_sat_cnt #(.W(CNT_W)) u_bcnt (
         .clk(clk), .rst(rst), .clr(snap_take), .inc(active && busy[i]),
         .cnt(b_live[i]), .nxt(b_nxt[i]), .sat_hit(b_hit[i])
      );
   end

   logic [NSTAGE:0] ovf;
   always_ff @(posedge clk) begin
      if (rst) ovf <= '0;
      else     ovf <= ovf | {b_hit, x_hit};
   end

   // ---------------- snapshots ----------------
   logic [CNT_W-1:0]             x_snap;
   logic [WIN_W-1:0]             t_snap;
   logic [PEAK_W-1:0]            p_snap;
   logic [NSTAGE-1:0][CNT_W-1:0] busy_snap;

   always_ff @(posedge clk) begin
      if (rst) begin
         x_snap    <= '0;
         t_snap    <= '0;
         p_snap    <= '0;
         busy_snap <= '0;
      end else if (snap_take) begin
         x_snap    <= x_nxt;
         t_snap    <= t_reg;
         p_snap    <= peak;
         busy_snap <= b_nxt;
      end
   end

   // ---------------- efficiency sequencer ----------------
   calc_st_e                     cs;
   logic [IDX_W-1:0]             idx;
   logic                         done;
   logic                         div_go;
   logic                         div_fin;
   logic [FRAC_W-1:0]            div_quo;
   logic [NSTAGE-1:0][EFF_W-1:0] e_snap;
   logic [DEN_W-1:0]             num_cur, den_cur;
   logic                         zero_case, cap_case, last_idx;

   always_comb begin
      num_cur   = DEN_W'(x_snap);
      den_cur   = DEN_W'(busy_snap[idx]) * DEN_W'(p_snap);
      zero_case = (busy_snap[idx] == '0) || (p_snap == '0);
      cap_case  = num_cur >= den_cur;
      last_idx  = (idx == IDX_W'(NSTAGE - 1));
   end

   pem_frac_div #(.DW(DEN_W), .QW(FRAC_W)) u_div (
      .clk(clk), .rst(rst), .go(div_go), .num(num_cur), .den(den_cur),
      .quo(div_quo), .fin(div_fin)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cs     <= CS_IDLE;
         idx    <= '0;
         done   <= 1'b0;
         div_go <= 1'b0;
         e_snap <= '0;
      end else begin
         div_go <= 1'b0;
         if (snap_take) begin
            cs   <= CS_PICK;
            idx  <= '0;
            done <= 1'b0;
         end else begin
            case (cs)
               CS_PICK: begin
                  if (zero_case || cap_case) begin
                     e_snap[idx] <= zero_case ? '0 : EFF_ONE;
                     if (last_idx) begin
                        cs   <= CS_IDLE;
                        done <= 1'b1;
                     end else begin
                        idx <= idx + IDX_W'(1);
                     end
                  end else begin
                     div_go <= 1'b1;
                     cs     <= CS_WAIT;
                  end
               end
               CS_WAIT: begin
                  if (div_fin && !div_go) begin
                     e_snap[idx] <= {1'b0, div_quo};
                     if (last_idx) begin
                        cs   <= CS_IDLE;
                        done <= 1'b1;
                     end else begin
                        idx <= idx + IDX_W'(1);
                        cs  <= CS_PICK;
                     end
                  end
               end
               default: cs <= CS_IDLE;
            endcase
         end
      end
   end

   // ---------------- read port ----------------
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (rd_addr == ADDR_W'(A_STATUS)) begin
         rd_mux[0]           = done;
         rd_mux[ST_XOVF_BIT] = ovf[0];
         for (int i = 0; i < NSTAGE; i++) rd_mux[ST_SOVF_BIT + i] = ovf[i + 1];
      end
      if (rd_addr == ADDR_W'(A_XCNT)) rd_mux = DATA_W'(x_snap);
      if (rd_addr == ADDR_W'(A_WIN))  rd_mux = DATA_W'(t_snap);
      if (rd_addr == ADDR_W'(A_PEAK)) rd_mux = DATA_W'(p_snap);
      for (int i = 0; i < NSTAGE; i++) begin
         if (rd_addr == ADDR_W'(A_BUSY_BASE + i)) rd_mux = DATA_W'(busy_snap[i]);
         if (rd_addr == ADDR_W'(A_EFF_BASE + i))  rd_mux = DATA_W'(e_snap[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) rd_data <= '0;
      else     rd_data <= rd_mux;
   end
endmodule

// File: rtl/pem_chk.sv
module pem_chk #(
   parameter int unsigned NSTAGE = 4,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned WIN_W  = 16
) (
   input logic                         clk,
   input logic                         rst,
   input logic                         active,
   input logic [WIN_W-1:0]             cyc,
   input logic [WIN_W-1:0]             t_reg,
   input logic [CNT_W-1:0]             x_live,
   input logic                         snap_take,
   input logic                         done,
   input logic [NSTAGE:0]              ovf,
   input logic [NSTAGE-1:0][15:0]      e_snap,
   input logic [NSTAGE-1:0][CNT_W-1:0] busy_snap
);
   assert_cyc_bound_R1: assert property (@(posedge clk) disable iff (rst)
      active |-> (cyc < t_reg));

   assert_idle_clear_R2: assert property (@(posedge clk) disable iff (rst)
      !active |-> (x_live == '0));

   assert_done_clr_R7: assert property (@(posedge clk) disable iff (rst)
      snap_take |=> !done);

   assert_no_overflow_loss_R8: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((ovf & $past(ovf)) == $past(ovf)));

   for (genvar i = 0; i < NSTAGE; i++) begin : g_eff
      assert_eff_cap_R5: assert property (@(posedge clk) disable iff (rst)
         e_snap[i] <= 16'h8000);

      assert_zero_eff_R6: assert property (@(posedge clk) disable iff (rst)
         (done && (busy_snap[i] == '0)) |-> (e_snap[i] == '0));
   end
endmodule

bind pipe_eff_mon pem_chk #(.NSTAGE(NSTAGE), .CNT_W(CNT_W), .WIN_W(WIN_W)) u_chk (
   .clk(clk), .rst(rst), .active(active), .cyc(cyc), .t_reg(t_reg),
   .x_live(x_live), .snap_take(snap_take), .done(done), .ovf(ovf),
   .e_snap(e_snap), .busy_snap(busy_snap)
);

// File: tb/pipe_eff_mon_bench.sv
module pipe_eff_mon_bench;
   localparam int CLK_P = 10;
   localparam int N  = 4;
   localparam int CW = 8;
   localparam int WW = 12;
   localparam int PW = 4;
   localparam int AW = 5;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst;
   logic          start, stop, retire;
   logic [WW-1:0] win_len;
   logic [PW-1:0] peak;
   logic [N-1:0]  busy;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] rd_data;

   int tests = 0;
   int fails = 0;
   bit ended = 0;

   always #(CLK_P/2) clk = ~clk;

   pipe_eff_mon #(.NSTAGE(N), .CNT_W(CW), .WIN_W(WW), .PEAK_W(PW), .ADDR_W(AW), .DATA_W(DW))
      u_pipe_eff_mon (
         .clk(clk), .rst(rst), .start(start), .stop(stop), .win_len(win_len),
         .peak(peak), .retire(retire), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
      );

   // {T[12], P[4], retire period[4] (0 = never), busy duty per stage[16]: nibble i = cycles of 4}
   localparam logic [35:0] VECS [0:5] = '{
      {12'd20,  4'd1, 4'd1, 16'h4444},
      {12'd40,  4'd1, 4'd2, 16'h0124},
      {12'd60,  4'd2, 4'd3, 16'h1234},
      {12'd100, 4'd3, 4'd5, 16'h4321},
      {12'd7,   4'd1, 4'd0, 16'h4444},
      {12'd50,  4'd0, 4'd1, 16'h4444}
   };

   int exp_x;
   int exp_b [N];

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input int addr, output logic [DW-1:0] val);
      @(negedge clk);
      rd_addr = AW'(addr);
      @(negedge clk);
      val = rd_data;
   endtask

   function automatic int eff(input int x, input int b, input int p);
      if (b == 0 || p == 0) return 0;
      if (x >= b * p) return 32'h8000;
      return (x * 32768) / (b * p);
   endfunction

   task automatic wait_done(input string req);
      logic [DW-1:0] s;
      int n = 0;
      s = '0;
      while (s[0] !== 1'b1 && n < 400) begin
         rd(0, s);
         n++;
      end
      chk(req, DW'(s[0]), 32'd1);
   endtask

   // one window with stop held high; events outside it are driven high to prove they are ignored
   task automatic run_window(input int t, input int p, input int rper, input logic [15:0] bon);
      @(negedge clk);
      start = 1'b1; win_len = WW'(t); peak = PW'(p); stop = 1'b1;
      retire = 1'b1; busy = '1;
      exp_x = 0;
      for (int i = 0; i < N; i++) exp_b[i] = 0;
      for (int k = 0; k < t; k++) begin
         @(negedge clk);
         start = 1'b0;
         retire = (rper != 0) && (k % rper == 0);
         for (int i = 0; i < N; i++) busy[i] = (k % 4) < int'(bon[4*i +: 4]);
         if (retire && exp_x < 255) exp_x++;
         for (int i = 0; i < N; i++) if (busy[i] && exp_b[i] < 255) exp_b[i]++;
      end
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         retire = 1'b1; busy = '1;
      end
      @(negedge clk);
      retire = 1'b0; busy = '0;
   endtask

   task automatic check_results(input int p);
      logic [DW-1:0] v;
      rd(1, v); chk("R2 retire count", v, DW'(exp_x));
      for (int i = 0; i < N; i++) begin
         rd(8 + i, v); chk("R3 busy count", v, DW'(exp_b[i]));
      end
      for (int i = 0; i < N; i++) begin
         rd(16 + i, v);
         if (exp_b[i] == 0 || p == 0) chk("R6 zero-operand efficiency", v, 32'd0);
         else                         chk("R5 efficiency", v, DW'(eff(exp_x, exp_b[i], p)));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         fails++;
         tests++;
         $display("FAIL watchdog: run did not finish actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      rst = 1'b1; start = 1'b0; stop = 1'b0; retire = 1'b0; busy = '0;
      win_len = '0; peak = '0; rd_addr = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R10: reset state
      rd(0, v);  chk("R10 status after reset", v, 32'd0);
      rd(1, v);  chk("R10 X after reset", v, 32'd0);
      rd(2, v);  chk("R10 T after reset", v, 32'd0);
      rd(16, v); chk("R10 efficiency after reset", v, 32'd0);

      // R1: start with zero length is ignored
      @(negedge clk);
      start = 1'b1; win_len = '0; retire = 1'b1; busy = '1;
      @(negedge clk);
      start = 1'b0;
      repeat (30) @(negedge clk);
      retire = 1'b0; busy = '0;
      rd(0, v); chk("R1 zero-length start ignored (done)", v, 32'd0);
      rd(1, v); chk("R1 zero-length start ignored (X)", v, 32'd0);

      // R2 R3 R5 R6 R7: vector table
      for (int n = 0; n < 6; n++) begin
         int t, p, rp;
         logic [15:0] bn;
         t  = int'(VECS[n][35:24]);
         p  = int'(VECS[n][23:20]);
         rp = int'(VECS[n][19:16]);
         bn = VECS[n][15:0];
         run_window(t, p, rp, bn);
         wait_done("R7 done after window");
         rd(2, v); chk("R1 window length readback", v, DW'(t));
         rd(3, v); chk("R5 peak readback", v, DW'(p));
         check_results(p);
      end

      // R4: automatic restart, stray start mid-window ignored (R1)
      @(negedge clk);
      start = 1'b1; win_len = WW'(8); peak = PW'(1); stop = 1'b0;
      retire = 1'b0; busy = '0;
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         start = (k == 11);
         if (k == 11) win_len = WW'(2);
         stop = (k >= 8);
         retire = (k < 8) ? 1'b1 : (k % 2 == 0);
         busy = (k < 8) ? 4'b1111 : 4'b0011;
      end
      @(negedge clk);
      start = 1'b0; retire = 1'b1; busy = '1;
      repeat (3) @(negedge clk);
      retire = 1'b0; busy = '0;
      wait_done("R7 done after restarted window");
      rd(1, v);  chk("R4 second window X counts only its own retires", v, 32'd4);
      rd(8, v);  chk("R4 second window busy stage0", v, 32'd8);
      rd(10, v); chk("R4 second window busy stage2 cleared", v, 32'd0);
      rd(2, v);  chk("R1 stray start did not change length", v, 32'd8);
      rd(16, v); chk("R5 efficiency 4 of 8", v, 32'h4000);

      // R9: unmapped addresses
      rd(4, v);  chk("R9 unmapped address 4", v, 32'd0);
      rd(31, v); chk("R9 unmapped address 31", v, 32'd0);

      // R8: saturation with sticky overflow
      run_window(300, 1, 1, 16'h0004);
      wait_done("R7 done after saturating window");
      rd(1, v);  chk("R8 X saturates", v, 32'd255);
      rd(8, v);  chk("R8 busy stage0 saturates", v, 32'd255);
      rd(9, v);  chk("R8 busy stage1 idle", v, 32'd0);
      rd(16, v); chk("R8 efficiency at saturation", v, 32'h8000);
      rd(0, v);  chk("R8 sticky overflow flags", v, 32'h0001_0101);

      // R10: reset clears flags and snapshots
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      rd(0, v); chk("R10 status cleared by reset", v, 32'd0);
      rd(8, v); chk("R10 busy snapshot cleared by reset", v, 32'd0);

      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule